// File: doc/BRIEF.md
# ADC Selection Register with Boundary-Deferred Update

This block is the byte-bus register front end of a successive-approximation converter. It keeps one 8-bit selection register made of three fields: a 2-bit reference select in bits 7:6, a result-alignment flag in bit 5, and a 5-bit channel/gain select in bits 4:0. It also keeps a 10-bit holding register for the last conversion result, which software reads as two bytes. The analog multiplexer, the gain stage and the converter itself sit outside the block. A conversion engine is represented by a busy level, a one-cycle done pulse and a 10-bit raw result.

Software writes always land in the register copy that it reads back. The copy that steers the converter (reference and channel/gain) only follows that register when the engine is idle or at the end of a conversion, so a running conversion never sees its inputs change. The alignment flag is not deferred: it selects the layout of the two result bytes combinationally, so changing it reshapes the readback at once, even mid-conversion. Results arrive as a done strobe with data. The strobe acts as a valid with no ready, because the holding register accepts a result in every cycle and never applies back-pressure. The engine must hold its result stable only in the done cycle.

Top module: `adcsel_top`

## Requirements
- R1: While reset is active, and on release, the selection register, the active reference and channel fields and the holding register are all zero, so reads at addresses 0, 1 and 2 return 0x00.
- R2: A write at address 0 is returned by a read at address 0 from the next cycle on, whether or not a conversion is busy.
- R3: With `conv_busy` low, a write at address 0 appears on `act_ref` (data bits 7:6) and `act_chan` (data bits 4:0) after the next clock edge.
- R4: While `conv_busy` is high and `conv_done` is low, `act_ref` and `act_chan` keep their values; a pending write is applied in the cycle `conv_done` is high.
- R5: When a write at address 0 and `conv_done` occur in the same cycle, the active fields take the value written in that cycle.
- R6: The holding register loads `conv_result` on each cycle `conv_done` is high and is unchanged otherwise.
- R7: With bit 5 of the selection register set (left adjust), address 2 reads result bits 9:2 and address 1 reads result bits 1:0 in its bits 7:6 with bits 5:0 zero (0x270 reads as 0x9C / 0x00).
- R8: With bit 5 clear (right adjust), address 1 reads result bits 7:0 and address 2 reads result bits 9:8 in its bits 1:0 with bits 7:2 zero (0x270 reads as 0x70 / 0x02).
- R9: A change of bit 5 changes the result bytes read on the cycle after the write, even while a conversion is busy.
- R10: `ref_sel_oh` is one-hot on the active reference code: bit 0 for 00 (external reference pin), bit 1 for 01 (supply), bit 2 for 10 (internal 1.1 V), bit 3 for 11 (internal 2.56 V).
- R11: Writes at addresses 1, 2 and 3 leave the selection register unchanged, and a read at address 3 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe for the byte bus |
| bus_addr | input | 2 | Register address: 0 select, 1 low result byte, 2 high result byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| conv_busy | input | 1 | Conversion engine is converting |
| conv_done | input | 1 | One-cycle strobe marking the end of a conversion; acts as result valid |
| conv_result | input | 10 | Raw two's-complement or unsigned result, valid with `conv_done` |
| act_ref | output | 2 | Reference code currently applied to the converter |
| act_chan | output | 5 | Channel/gain code currently applied to the converter |
| ref_sel_oh | output | 4 | One-hot decode of `act_ref` |

## Verification
The bound checker watches, on every cycle, that the active fields freeze during a busy conversion, that they pick up a write when the engine is idle or finishing, that a same-cycle write wins at the done boundary, that the readback register and holding register load only what they should, and that the reference decode stays one-hot. The byte layout under both alignment settings, the immediate reformatting during a busy conversion and the exact reset values can only be shown by the bench's reads. The bench does this with the worked 0x270 example and with random results, alignments and engine timing.

// File: rtl/adcsel_pkg.sv
package adcsel_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_SEL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_RLO = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_RHI = 2'd2;

  typedef enum logic [1:0] {
    REF_EXT_PIN = 2'b00,
    REF_SUPPLY  = 2'b01,
    REF_INT_1V1 = 2'b10,
    REF_INT_2V56 = 2'b11
  } ref_code_e;
endpackage

// File: rtl/adcsel_selreg.sv
module adcsel_selreg #(
  parameter int REF_W  = 2,
  parameter int CHAN_W = 5,
  localparam int SEL_W = REF_W + 1 + CHAN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic [SEL_W-1:0]  wdata,
  input  logic              conv_busy,
  input  logic              conv_done,
  output logic [SEL_W-1:0]  sel_q,
  output logic [REF_W-1:0]  act_ref,
  output logic [CHAN_W-1:0] act_chan
);
  localparam int ALIGN_POS = CHAN_W;
  localparam int REF_LSB   = CHAN_W + 1;

  logic [SEL_W-1:0]  sel_next;
  logic              boundary;
  logic [REF_W-1:0]  ref_q;
  logic [CHAN_W-1:0] chan_q;

  // Newest software value: a write in this cycle wins over the stored one.
  always_comb begin
    sel_next = wr_sel ? wdata : sel_q;
    boundary = !conv_busy || conv_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (wr_sel) begin
      sel_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= '0;
      chan_q <= '0;
    end else if (boundary) begin
      ref_q  <= sel_next[SEL_W-1:REF_LSB];
      chan_q <= sel_next[ALIGN_POS-1:0];
    end
  end

  assign act_ref  = ref_q;
  assign act_chan = chan_q;
endmodule

// File: rtl/adcsel_result.sv
module adcsel_result #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W,
  localparam int PAD_W  = WORD_W - RES_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [RES_W-1:0]  res_data,
  input  logic              left_adj,
  output logic [RES_W-1:0]  hold_q,
  output logic [BYTE_W-1:0] byte_lo,
  output logic [BYTE_W-1:0] byte_hi
);
  logic [WORD_W-1:0] word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (res_valid) begin
      hold_q <= res_data;
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      always_comb begin
        if (left_adj) word = {hold_q, {PAD_W{1'b0}}};
        else          word = {{PAD_W{1'b0}}, hold_q};
      end
    end else begin : g_nopad
      always_comb word = hold_q;
    end
  endgenerate

  assign byte_lo = word[BYTE_W-1:0];
  assign byte_hi = word[WORD_W-1:BYTE_W];
endmodule

// File: rtl/adcsel_refdec.sv
module adcsel_refdec #(
  parameter int REF_W = 2,
  localparam int NREF = 1 << REF_W
) (
  input  logic [REF_W-1:0] ref_code,
  output logic [NREF-1:0]  ref_oh
);
  for (genvar i = 0; i < NREF; i++) begin : g_dec
    assign ref_oh[i] = (ref_code == REF_W'(i));
  end
endmodule

// File: rtl/adcsel_top.sv
module adcsel_top #(
  parameter int REF_W  = 2,
  parameter int CHAN_W = 5,
  parameter int RES_W  = 10,
  localparam int SEL_W = REF_W + 1 + CHAN_W,
  localparam int NREF  = 1 << REF_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_wr,
  input  logic [adcsel_pkg::ADDR_W-1:0]   bus_addr,
  input  logic [SEL_W-1:0]                bus_wdata,
  output logic [SEL_W-1:0]                bus_rdata,
  input  logic                            conv_busy,
  input  logic                            conv_done,
  input  logic [RES_W-1:0]                conv_result,
  output logic [REF_W-1:0]                act_ref,
  output logic [CHAN_W-1:0]               act_chan,
  output logic [NREF-1:0]                 ref_sel_oh
);
  import adcsel_pkg::*;

  logic             wr_sel;
  logic [SEL_W-1:0] sel_q;
  logic [RES_W-1:0] hold_q;
  logic [SEL_W-1:0] byte_lo;
  logic [SEL_W-1:0] byte_hi;

  assign wr_sel = bus_wr && (bus_addr == ADDR_SEL);

  adcsel_selreg #(.REF_W(REF_W), .CHAN_W(CHAN_W)) selreg_i (
    .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wdata(bus_wdata),
    .conv_busy(conv_busy), .conv_done(conv_done),
    .sel_q(sel_q), .act_ref(act_ref), .act_chan(act_chan)
  );

  adcsel_result #(.RES_W(RES_W), .BYTE_W(SEL_W)) result_i (
    .clk(clk), .rst_n(rst_n), .res_valid(conv_done), .res_data(conv_result),
    .left_adj(sel_q[CHAN_W]), .hold_q(hold_q),
    .byte_lo(byte_lo), .byte_hi(byte_hi)
  );

  adcsel_refdec #(.REF_W(REF_W)) refdec_i (
    .ref_code(act_ref), .ref_oh(ref_sel_oh)
  );

  always_comb begin
    unique case (bus_addr)
      ADDR_SEL: bus_rdata = sel_q;
      ADDR_RLO: bus_rdata = byte_lo;
      ADDR_RHI: bus_rdata = byte_hi;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/adcsel_chk.sv
module adcsel_chk #(
  parameter int REF_W  = 2,
  parameter int CHAN_W = 5,
  parameter int RES_W  = 10,
  localparam int SEL_W = REF_W + 1 + CHAN_W,
  localparam int NREF  = 1 << REF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [1:0]        bus_addr,
  input logic [SEL_W-1:0]  bus_wdata,
  input logic              conv_busy,
  input logic              conv_done,
  input logic [RES_W-1:0]  conv_result,
  input logic [SEL_W-1:0]  sel_q,
  input logic [RES_W-1:0]  hold_q,
  input logic [REF_W-1:0]  act_ref,
  input logic [CHAN_W-1:0] act_chan,
  input logic [NREF-1:0]   ref_sel_oh
);
  logic wr0;
  logic [SEL_W-2:0] wfields;
  assign wr0 = bus_wr && (bus_addr == 2'd0);
  assign wfields = {bus_wdata[SEL_W-1:CHAN_W+1], bus_wdata[CHAN_W-1:0]};

  a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
    wr0 |=> sel_q == $past(bus_wdata));

  a_r11_other_addr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    !wr0 |=> $stable(sel_q));

  a_r3_idle_apply: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0 && !conv_busy) |=> {act_ref, act_chan} == $past(wfields));

  a_r4_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_busy && !conv_done) |=> ($stable(act_ref) && $stable(act_chan)));

  a_r5_write_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0 && conv_done) |=> {act_ref, act_chan} == $past(wfields));

  a_r6_hold_load: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> hold_q == $past(conv_result));

  a_r6_hold_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> $stable(hold_q));

  a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ref_sel_oh) == 1 && ref_sel_oh[act_ref]);
endmodule

bind adcsel_top adcsel_chk #(.REF_W(REF_W), .CHAN_W(CHAN_W), .RES_W(RES_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .conv_busy(conv_busy), .conv_done(conv_done),
  .conv_result(conv_result), .sel_q(sel_q), .hold_q(hold_q),
  .act_ref(act_ref), .act_chan(act_chan), .ref_sel_oh(ref_sel_oh)
);

// File: tb/adcsel_top_tb_top.sv
module adcsel_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       conv_busy = 1'b0;
  logic       conv_done = 1'b0;
  logic [9:0] conv_result = 10'h000;
  logic [1:0] act_ref;
  logic [4:0] act_chan;
  logic [3:0] ref_sel_oh;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // bench model
  logic [7:0] m_sel = 8'h00;
  logic [1:0] m_ref = 2'b00;
  logic [4:0] m_chan = 5'h00;
  logic [9:0] m_hold = 10'h000;

  always #2 clk = ~clk;

  adcsel_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_busy(conv_busy),
    .conv_done(conv_done), .conv_result(conv_result), .act_ref(act_ref),
    .act_chan(act_chan), .ref_sel_oh(ref_sel_oh)
  );

  function automatic logic [7:0] exp_rd(input logic [1:0] a, input logic [7:0] s,
                                        input logic [9:0] h);
    logic [15:0] w;
    w = s[5] ? {h, 6'b0} : {6'b0, h};
    case (a)
      2'd0: return s;
      2'd1: return w[7:0];
      2'd2: return w[15:8];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic wr, input logic [1:0] a, input logic [7:0] wd,
                     input logic bsy, input logic dn, input logic [9:0] res);
    string t_act;
    string t_rd;
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = wd;
    conv_busy = bsy; conv_done = dn; conv_result = res;
    t_act = (bsy && !dn) ? "R4" : ((dn && wr && a == 2'd0) ? "R5" : "R3");
    @(posedge clk);
    if (wr && a == 2'd0) m_sel = wd;
    if (!bsy || dn) begin m_ref = m_sel[7:6]; m_chan = m_sel[4:0]; end
    if (dn) m_hold = res;
    #1;
    t_rd = (a == 2'd0) ? "R2" : ((a == 2'd3) ? "R11" : (m_sel[5] ? "R7" : "R8"));
    chk(t_act, {act_ref, act_chan}, {m_ref, m_chan});
    chk("R10", ref_sel_oh, 4'b0001 << m_ref);
    chk(t_rd, bus_rdata, exp_rd(a, m_sel, m_hold));
  endtask

  task automatic rd_now(input string tag, input logic [1:0] a, input logic [7:0] exp);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = a; conv_done = 1'b0;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A1C));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    chk("R1", {act_ref, act_chan}, 0);
    chk("R1", ref_sel_oh, 4'b0001);
    for (int a = 0; a < 3; a++) begin
      bus_addr = 2'(a); #1;
      chk("R1", bus_rdata, 0);
    end
    @(negedge clk); rst_n = 1'b1;

    // Directed: worked example, left adjust (R7) and right adjust (R8)
    cyc(1, 2'd0, 8'hED, 0, 0, 10'h0);
    chk("R3", {act_ref, act_chan}, {2'b11, 5'h0D});
    cyc(0, 2'd0, 8'h00, 1, 1, 10'h270);
    rd_now("R7", 2'd2, 8'h9C);
    rd_now("R7", 2'd1, 8'h00);
    cyc(1, 2'd0, 8'hCD, 0, 0, 10'h0);
    rd_now("R8", 2'd1, 8'h70);
    rd_now("R8", 2'd2, 8'h02);

    // R9: alignment change during a busy conversion, R4: active frozen
    cyc(0, 2'd1, 8'h00, 1, 0, 10'h0);
    cyc(1, 2'd0, 8'h65, 1, 0, 10'h0);
    rd_now("R9", 2'd2, 8'h9C);
    rd_now("R9", 2'd0, 8'h65);
    chk("R4", {act_ref, act_chan}, {2'b11, 5'h0D});
    cyc(0, 2'd2, 8'h00, 1, 0, 10'h0);
    // R5: write coincident with done wins
    cyc(1, 2'd0, 8'h93, 1, 1, 10'h1FF);
    chk("R5", {act_ref, act_chan}, {2'b10, 5'h13});
    // R11: other-address writes ignored, address 3 reads zero
    cyc(1, 2'd1, 8'hFF, 0, 0, 10'h0);
    cyc(1, 2'd3, 8'hAA, 0, 0, 10'h0);
    rd_now("R11", 2'd0, 8'h93);
    rd_now("R11", 2'd3, 8'h00);
    // R10: each reference code
    for (int r = 0; r < 4; r++) begin
      cyc(1, 2'd0, {2'(r), 6'h01}, 0, 0, 10'h0);
      chk("R10", ref_sel_oh, 4'b0001 << r);
    end

    // Constrained random: engine conversions of random length
    begin
      bit busy_s = 0;
      int left = 0;
      for (int i = 0; i < 3000; i++) begin
        logic dn;
        logic [1:0] a;
        dn = 1'b0;
        if (!busy_s) begin
          if ($urandom_range(0, 3) == 0) begin busy_s = 1; left = $urandom_range(1, 6); end
        end else if (left == 0) begin
          dn = 1'b1;
        end else begin
          left--;
        end
        a = 2'($urandom_range(0, 3));
        cyc($urandom_range(0, 2) == 0, a, 8'($urandom()), busy_s, dn, 10'($urandom()));
        if (dn) busy_s = 0;
      end
    end

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule